// File: doc/BRIEF.md
# Source-Side Snoop Response Aggregator

This block runs the requesting side of one coherent read for a single cache line. A start command, given while the block is idle, sends a read request pulse to the home node. The block then counts the snoop replies that come back on the response channel. How many it expects is taken from a mask of the nodes that take part. Some request types also need a reply from the requesting node to itself. For those, the block makes the reply internally and holds it back while a hold input is high. The internal reply counts as one of the expected replies.

Once every expected reply has been counted, the block sends a one-cycle notice to the home node. The home node may then forward the next request to the same line. This notice does not wait for data. Data replies arrive on a separate data channel, and they may come before or after the notice. A snoop reply can say that copyback data is on its way. In that case the block also waits for a copyback data beat, so the copyback can be merged. Once the notice has gone out and all owed data has arrived, the transaction retires with a one-cycle done pulse. Any traffic that breaks the protocol sets a sticky error flag.

Top module: `coh_src_tracker`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `req_valid`, `notify_home`, `done`, `busy` and `proto_err` are all low.
- R2: `start` is accepted only when `busy` is low. An accepted start raises `req_valid` for exactly one cycle, in the cycle after `start` is sampled, and `busy` rises in that same cycle. A `start` sampled while `busy` is high has no effect.
- R3: At an accepted start, the expected-reply count is loaded with the number of ones in `present_mask`. Bit i of the mask set means node i takes part. Each counted snoop reply lowers the count by one.
- R4: `notify_home` is high for exactly one cycle, one cycle after the count is first seen at zero. This happens whether or not any data has arrived.
- R5: When `start_self` is high at an accepted start and the mask is not empty, one of the expected replies is made internally. It is counted in the first collection cycle in which `self_hold` is low. While `self_hold` stays high, the transaction cannot reach the notice.
- R6: A counted reply with `rsp_copyback` = 1 makes retirement also wait for a data beat with `data_copyback` = 1. A data beat with `data_copyback` = 0 is the memory data, and it is always required.
- R7: `done` is high for exactly one cycle, at the earliest one cycle after `notify_home`. It comes once the memory beat, and any owed copyback beat, have been received. `busy` is low in the cycle `done` is high.
- R8: `proto_err` sets and stays set until reset in any of these cases: a snoop reply arrives outside reply collection; a snoop reply arrives when no external replies remain owed; a data beat arrives while idle. Such traffic is not counted.
- R9: With an all-zero mask, `notify_home` comes two cycles after `start` is sampled, and no reply is needed.
- R10: An external reply and the internal self reply in the same cycle lower the count by two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a coherent read transaction |
| start_self | input | 1 | Request type needs an internal self snoop reply |
| present_mask | input | NODES | Nodes that will send a snoop reply |
| self_hold | input | 1 | Hold back the internal self reply |
| rsp_valid | input | 1 | One snoop reply beat on the response channel |
| rsp_copyback | input | 1 | The reply announces copyback data |
| data_valid | input | 1 | One data beat on the data channel |
| data_copyback | input | 1 | The data beat is copyback data, not memory data |
| req_valid | output | 1 | Read request pulse to the home node |
| notify_home | output | 1 | All snoop replies collected; next request may be forwarded |
| done | output | 1 | Transaction retired |
| busy | output | 1 | A transaction is outstanding |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with NODES set to 4, so the mask is one bit wider than the default. This covers partial masks, the full mask, an empty mask, and the case where an external reply and the self reply decrement the count in the same cycle. It also covers data beats that arrive before the notice and a copyback beat that arrives after the memory beat. Illegal traffic is sent while idle, during the drain phase, and as an excess reply, to exercise the sticky error flag.

// File: rtl/coh_src_pkg.sv
package coh_src_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SNOOP = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;
endpackage

// File: rtl/coh_snp_counter.sv
module coh_snp_counter #(
  parameter int NODES = 3,
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_self,
  input  logic             active,
  input  logic             ext_rsp,
  input  logic             self_hold,
  output logic             ext_take,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;
  logic             self_pend;
  logic             self_fire;
  logic             ext_room;

  always_comb begin
    self_fire = active && self_pend && !self_hold;
    // external replies may only fill slots not reserved for the self reply
    ext_room  = cnt > CNT_W'(self_pend);
    ext_take  = active && ext_rsp && ext_room;
    zero      = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      self_pend <= 1'b0;
    end else if (load) begin
      cnt       <= load_val;
      self_pend <= load_self && (load_val != '0);
    end else begin
      cnt <= cnt - CNT_W'(ext_take) - CNT_W'(self_fire);
      if (self_fire) self_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/coh_data_tracker.sv
module coh_data_tracker (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic active,
  input  logic data_valid,
  input  logic data_cb,
  input  logic cb_flag,
  output logic ready
);
  logic mem_seen;
  logic cb_need;
  logic cb_seen;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mem_seen <= 1'b0;
      cb_need  <= 1'b0;
      cb_seen  <= 1'b0;
    end else begin
      if (active && data_valid && !data_cb) mem_seen <= 1'b1;
      if (active && data_valid && data_cb)  cb_seen  <= 1'b1;
      if (cb_flag)                          cb_need  <= 1'b1;
    end
  end

  always_comb ready = mem_seen && (!cb_need || cb_seen);
endmodule

// File: rtl/coh_src_tracker.sv
module coh_src_tracker
  import coh_src_pkg::*;
#(
  parameter int NODES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_self,
  input  logic [NODES-1:0] present_mask,
  input  logic             self_hold,
  input  logic             rsp_valid,
  input  logic             rsp_copyback,
  input  logic             data_valid,
  input  logic             data_copyback,
  output logic             req_valid,
  output logic             notify_home,
  output logic             done,
  output logic             busy,
  output logic             proto_err
);
  localparam int CNT_W = $clog2(NODES + 1);

  phase_e     phase;
  logic       accept;
  logic       in_snoop;
  logic       ext_take;
  logic       cnt_zero;
  logic       data_ready;
  logic       bad;
  logic [CNT_W-1:0] mask_ones;

  always_comb begin
    accept    = (phase == PH_IDLE) && start;
    in_snoop  = (phase == PH_SNOOP);
    mask_ones = CNT_W'($countones(present_mask));
    bad       = (rsp_valid && !ext_take) ||
                (data_valid && (phase == PH_IDLE));
  end

  coh_snp_counter #(.NODES(NODES)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_val  (mask_ones),
    .load_self (start_self),
    .active    (in_snoop),
    .ext_rsp   (rsp_valid),
    .self_hold (self_hold),
    .ext_take  (ext_take),
    .zero      (cnt_zero)
  );

  coh_data_tracker u_data (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept),
    .active     (phase != PH_IDLE),
    .data_valid (data_valid),
    .data_cb    (data_copyback),
    .cb_flag    (ext_take && rsp_copyback),
    .ready      (data_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      req_valid   <= 1'b0;
      notify_home <= 1'b0;
      done        <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      req_valid   <= accept;
      notify_home <= in_snoop && cnt_zero;
      done        <= (phase == PH_DRAIN) && data_ready;
      if (bad) proto_err <= 1'b1;
      unique case (phase)
        PH_IDLE:  if (accept)     phase <= PH_SNOOP;
        PH_SNOOP: if (cnt_zero)   phase <= PH_DRAIN;
        PH_DRAIN: if (data_ready) phase <= PH_IDLE;
        default:                  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb busy = (phase != PH_IDLE);
endmodule

// File: rtl/coh_src_tracker_chk.sv
module coh_src_tracker_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic req_valid,
  input logic notify_home,
  input logic done,
  input logic busy,
  input logic proto_err
);
  assert_req_single_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  assert_req_busy_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !req_valid);
  assert_notify_single_R4: assert property (@(posedge clk) disable iff (rst)
    notify_home |=> !notify_home);
  assert_notify_busy_R4: assert property (@(posedge clk) disable iff (rst)
    notify_home |-> busy);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind coh_src_tracker coh_src_tracker_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .req_valid   (req_valid),
  .notify_home (notify_home),
  .done        (done),
  .busy        (busy),
  .proto_err   (proto_err)
);

// File: tb/coh_src_tracker_test.sv
module coh_src_tracker_test;
  localparam int NODES  = 4;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, start_self = 1'b0, self_hold = 1'b0;
  logic [NODES-1:0] present_mask = '0;
  logic rsp_valid = 1'b0, rsp_copyback = 1'b0;
  logic data_valid = 1'b0, data_copyback = 1'b0;
  logic req_valid, notify_home, done, busy, proto_err;

  int checks = 0;
  int errors = 0;
  string scen = "R1";
  bit started = 0;

  // behavioural reference state
  int m_ph = 0, m_cnt = 0;
  bit m_selfp = 0, m_mem = 0, m_cbneed = 0, m_cbseen = 0;
  bit m_req = 0, m_ntf = 0, m_done = 0, m_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  coh_src_tracker #(.NODES(NODES)) uut (
    .clk(clk), .rst(rst), .start(start), .start_self(start_self),
    .present_mask(present_mask), .self_hold(self_hold),
    .rsp_valid(rsp_valid), .rsp_copyback(rsp_copyback),
    .data_valid(data_valid), .data_copyback(data_copyback),
    .req_valid(req_valid), .notify_home(notify_home), .done(done),
    .busy(busy), .proto_err(proto_err)
  );

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_selfp = 0; m_mem = 0; m_cbneed = 0;
      m_cbseen = 0; m_req = 0; m_ntf = 0; m_done = 0; m_err = 0;
    end else begin
      bit sfire, ready, take;
      int ph_now;
      ph_now = m_ph;
      ready  = m_mem && (!m_cbneed || m_cbseen);
      sfire  = (m_ph == 1) && m_selfp && !self_hold;
      take   = rsp_valid && (m_ph == 1) && (m_cnt > int'(m_selfp));
      m_req  = (m_ph == 0) && start;
      m_ntf  = (m_ph == 1) && (m_cnt == 0);
      m_done = (m_ph == 2) && ready;
      if ((rsp_valid && !take) || (data_valid && m_ph == 0)) m_err = 1;
      if (ph_now == 0) begin
        if (start) begin
          m_cnt = $countones(present_mask);
          m_selfp = start_self && (m_cnt > 0);
          m_mem = 0; m_cbneed = 0; m_cbseen = 0;
          m_ph = 1;
        end
      end else begin
        if (data_valid) begin
          if (data_copyback) m_cbseen = 1; else m_mem = 1;
        end
        if (ph_now == 1) begin
          if (take && rsp_copyback) m_cbneed = 1;
          if (m_cnt == 0) m_ph = 2;
          else begin
            m_cnt = m_cnt - int'(take) - int'(sfire);
            if (sfire) m_selfp = 0;
          end
        end else if (ready) m_ph = 0;
      end
    end
  end

  task automatic check(string tag, string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) %s: actual %b expected %b at %0t",
               tag, scen, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R2", "req_valid",   req_valid,   m_req);
      check("R4", "notify_home", notify_home, m_ntf);
      check("R7", "done",        done,        m_done);
      check("R7", "busy",        busy,        m_ph != 0);
      check("R8", "proto_err",   proto_err,   m_err);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_start(logic [NODES-1:0] m, logic s);
    start = 1; present_mask = m; start_self = s;
    @(negedge clk);
    start = 0; start_self = 0;
  endtask
  task automatic send_rsp(logic cb);
    rsp_valid = 1; rsp_copyback = cb;
    @(negedge clk);
    rsp_valid = 0; rsp_copyback = 0;
  endtask
  task automatic send_data(logic cb);
    data_valid = 1; data_copyback = cb;
    @(negedge clk);
    data_valid = 0; data_copyback = 0;
  endtask
  task automatic reset_dut();
    rst = 1; idle(3); rst = 0; idle(2);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    scen = "R1"; reset_dut();
    // basic partial mask, data after notice
    scen = "R3"; do_start(4'b0111, 0); idle(2);
    send_rsp(0); send_rsp(0); idle(1); send_rsp(0); idle(3);
    send_data(0); idle(4);
    // early data, full mask, start while busy ignored
    scen = "R2"; do_start(4'b1111, 0); send_data(0);
    send_rsp(0); do_start(4'b0001, 0); send_rsp(0); send_rsp(0);
    send_rsp(0); idle(5);
    // self reply held back
    scen = "R5"; self_hold = 1; do_start(4'b0011, 1);
    send_rsp(0); idle(4); self_hold = 0; idle(3); send_data(0); idle(3);
    // copyback owed
    scen = "R6"; do_start(4'b0111, 0); send_rsp(1); send_rsp(0);
    send_rsp(0); send_data(0); idle(4); send_data(1); idle(3);
    // empty mask
    scen = "R9"; do_start(4'b0000, 1); idle(3); send_data(0); idle(3);
    // external and self reply in the same cycle
    scen = "R10"; do_start(4'b0111, 1); send_rsp(0); send_rsp(0);
    idle(2); send_data(0); idle(3);
    // protocol errors
    scen = "R8"; send_rsp(0); idle(3);
    reset_dut();
    do_start(4'b0001, 0); send_rsp(0); idle(2); send_rsp(0); send_data(0);
    idle(3);
    reset_dut();
    send_data(1); idle(3);
    do_start(4'b0011, 1); send_rsp(0); send_rsp(0); idle(2);
    send_data(0); idle(3);
    finish_run();
  end
endmodule